// File: doc/BRIEF.md
# Masked packed FP16 to uint32 lane controller

This block turns a packed vector of half-precision floating-point numbers into unsigned 32-bit integers, one conversion unit per lane. It accepts one operation per cycle and returns the result one cycle later. A length code selects 4, 8 or 16 active lanes. Every bit above the active width is written as zero.

Each lane converts either its own source element or, when the operand comes from memory and broadcast is requested, element 0. The rounding mode normally comes from the global setting. An embedded rounding field replaces it only for a full-width operation on a register source with the broadcast/rounding bit set. A per-lane write mask, enabled by a separate signal, picks the lanes that take a converted value. The other lanes are either zeroed or keep the previous destination contents. The invalid and inexact flags are ORed only over lanes that actually wrote a converted value.

Top module: `vcvt_lane_ctrl`

## Requirements
- R1: The length code `vlen_i` selects the active lane count: 0 gives 4 lanes, 1 gives 8 lanes, 2 gives 16 lanes, and 3 behaves like 2. Lane j occupies `dest_o[32*j+31:32*j]` and reads source element `src_i[16*j+15:16*j]`.
- R2: Each writing lane converts its FP16 input to uint32 under the effective rounding mode. NaN or infinity, or a negative value that is nonzero after rounding, gives 32'hFFFF_FFFF with invalid set and inexact clear. Any other input gives the rounded integer, and inexact is set when a fraction was discarded. Negative values that round to zero give 0.
- R3: The rounding codes are 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity and 3 toward zero. `emb_rc_i` is used only when `src_mem_i`=0, the length is 512 bits (code 2 or 3) and `bcst_i`=1. In every other case `glob_rc_i` is used.
- R4: When `src_mem_i`=1 and `bcst_i`=1, every active lane converts source element 0.
- R5: With `mask_en_i`=0, every active lane writes its converted value. With `mask_en_i`=1, only lanes whose `mask_i[j]`=1 write it.
- R6: An active lane that does not write takes 0 when `zero_i`=1. When `zero_i`=0 it takes the matching word of `dest_old_i`.
- R7: All `dest_o` bits from the active width up to bit 511 are 0.
- R8: `inval_o` and `inexact_o` are the OR of the lane flags over active, writing lanes only.
- R9: When `in_valid_i` is high at a clock edge, `out_valid_o` is high and the result is on `dest_o`/flags after that edge. Operations may arrive on back-to-back cycles. `out_valid_o` is low after any edge where `in_valid_i` was low.
- R10: After reset, `out_valid_o`, `dest_o`, `inval_o` and `inexact_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present |
| vlen_i | input | 2 | Length code (0:128, 1:256, 2/3:512) |
| src_i | input | 256 | Packed FP16 source, 16 elements |
| src_mem_i | input | 1 | Source operand comes from memory |
| bcst_i | input | 1 | Broadcast (memory) or rounding-override enable (register) |
| emb_rc_i | input | 2 | Embedded rounding mode |
| glob_rc_i | input | 2 | Global rounding mode |
| mask_i | input | 16 | Per-lane write mask |
| mask_en_i | input | 1 | Write mask in use |
| zero_i | input | 1 | 1: zero unwritten lanes, 0: merge |
| dest_old_i | input | 512 | Previous destination contents |
| out_valid_o | output | 1 | Result valid |
| dest_o | output | 512 | Destination result |
| inval_o | output | 1 | Invalid flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The state in this block is the output register, so most faults show up in the cycle right after the operation that exposes them. A wrong lane-activity or mask decode shows as nonzero bits above the active width, or as a merged word where a zero was expected. A wrong rounding-mode selection changes the integer in lanes that hold exact halves, such as 2.5. Flag faults show up when a NaN sits in a masked-off or inactive lane and the flags are not clean on the next cycle.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/fp16_u32_lane.sv
module fp16_u32_lane
  import fpcvt_pkg::*;
(
  input  logic [HALF_W-1:0] h_i,
  input  rmode_e            rm_i,
  output logic [WORD_W-1:0] val_o,
  output logic              inv_o,
  output logic              inx_o
);
  localparam int unsigned MAN_W  = 10;
  localparam int unsigned EXP_W  = 5;
  localparam int unsigned SIG_W  = MAN_W + 1;
  localparam int unsigned INT_AT = 15 + MAN_W;   // biased exponent of integer lsb
  localparam int unsigned FR_W   = INT_AT - 1;   // widest discarded fraction
  localparam int unsigned WIDE_W = SIG_W + FR_W;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [SIG_W-1:0] sig;
  logic [5:0]       e_eff;
  logic [5:0]       sh;
  logic [WIDE_W-1:0] wide;
  logic [SIG_W-1:0] q;
  logic [FR_W-1:0]  fr;
  logic             nz, gt, eq, inc;
  logic [SIG_W:0]   qr;
  logic [WORD_W-1:0] big;

  assign sgn   = h_i[HALF_W-1];
  assign ex    = h_i[HALF_W-2 -: EXP_W];
  assign sig   = {(ex != '0), h_i[MAN_W-1:0]};
  assign e_eff = (ex == '0) ? 6'd1 : {1'b0, ex};
  assign sh    = 6'(INT_AT) - e_eff;
  assign wide  = {sig, {FR_W{1'b0}}} >> sh;
  assign q     = wide[WIDE_W-1 -: SIG_W];
  assign fr    = wide[FR_W-1:0];
  assign nz    = (fr != '0);
  assign gt    = (fr > {1'b1, {(FR_W-1){1'b0}}});
  assign eq    = (fr == {1'b1, {(FR_W-1){1'b0}}});
  assign big   = {{(WORD_W-SIG_W){1'b0}}, sig} << (e_eff - 6'(INT_AT));

  always_comb begin
    unique case (rm_i)
      RM_NEAR: inc = gt | (eq & q[0]);
      RM_DOWN: inc = sgn & nz;
      RM_UP:   inc = ~sgn & nz;
      default: inc = 1'b0;
    endcase
  end

  assign qr = {1'b0, q} + {{SIG_W{1'b0}}, inc};

  always_comb begin
    val_o = '0;
    inv_o = 1'b0;
    inx_o = 1'b0;
    if (ex == '1) begin
      val_o = '1;
      inv_o = 1'b1;
    end else if (e_eff >= 6'(INT_AT)) begin
      // exact integer, never zero here
      if (sgn) begin
        val_o = '1;
        inv_o = 1'b1;
      end else begin
        val_o = big;
      end
    end else if (sgn && qr != '0) begin
      val_o = '1;
      inv_o = 1'b1;
    end else begin
      val_o = {{(WORD_W-SIG_W-1){1'b0}}, qr};
      inx_o = nz;
    end
  end
endmodule

// File: rtl/cvt_rm_select.sv
module cvt_rm_select
  import fpcvt_pkg::*;
(
  input  logic   src_mem_i,
  input  logic   bcst_i,
  input  logic   full_len_i,
  input  rmode_e emb_rc_i,
  input  rmode_e glob_rc_i,
  output rmode_e rm_o
);
  logic use_emb;
  assign use_emb = ~src_mem_i & full_len_i & bcst_i;
  assign rm_o    = use_emb ? emb_rc_i : glob_rc_i;
endmodule

// File: rtl/cvt_lane_merge.sv
module cvt_lane_merge #(
  parameter int unsigned W = 32
) (
  input  logic         active_i,
  input  logic         write_i,
  input  logic         zero_i,
  input  logic [W-1:0] conv_i,
  input  logic [W-1:0] old_i,
  input  logic         inv_i,
  input  logic         inx_i,
  output logic [W-1:0] word_o,
  output logic         inv_o,
  output logic         inx_o
);
  logic take;
  assign take = active_i & write_i;

  always_comb begin
    if (!active_i)    word_o = '0;
    else if (write_i) word_o = conv_i;
    else if (zero_i)  word_o = '0;
    else              word_o = old_i;
  end

  assign inv_o = take & inv_i;
  assign inx_o = take & inx_i;
endmodule

// File: rtl/vcvt_lane_ctrl.sv
module vcvt_lane_ctrl
  import fpcvt_pkg::*;
#(
  parameter int unsigned MAX_LANES = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic [1:0]                  vlen_i,
  input  logic [MAX_LANES*HALF_W-1:0] src_i,
  input  logic                        src_mem_i,
  input  logic                        bcst_i,
  input  logic [1:0]                  emb_rc_i,
  input  logic [1:0]                  glob_rc_i,
  input  logic [MAX_LANES-1:0]        mask_i,
  input  logic                        mask_en_i,
  input  logic                        zero_i,
  input  logic [MAX_LANES*WORD_W-1:0] dest_old_i,
  output logic                        out_valid_o,
  output logic [MAX_LANES*WORD_W-1:0] dest_o,
  output logic                        inval_o,
  output logic                        inexact_o
);
  localparam int unsigned DST_W     = MAX_LANES * WORD_W;
  localparam int unsigned MIN_LANES = MAX_LANES / 4;
  localparam int unsigned CNT_W     = $clog2(MAX_LANES + 1);

  logic [CNT_W-1:0]     n_act;
  logic                 full_len;
  logic                 bcast;
  rmode_e               rm;
  logic [DST_W-1:0]     dest_d;
  logic [MAX_LANES-1:0] lane_inv, lane_inx;

  always_comb begin
    unique case (vlen_i)
      2'd0:    n_act = CNT_W'(MIN_LANES);
      2'd1:    n_act = CNT_W'(2 * MIN_LANES);
      default: n_act = CNT_W'(MAX_LANES);
    endcase
  end

  assign full_len = vlen_i[1];
  assign bcast    = src_mem_i & bcst_i;

  cvt_rm_select u_rm (
    .src_mem_i  (src_mem_i),
    .bcst_i     (bcst_i),
    .full_len_i (full_len),
    .emb_rc_i   (rmode_e'(emb_rc_i)),
    .glob_rc_i  (rmode_e'(glob_rc_i)),
    .rm_o       (rm)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [HALF_W-1:0] elem;
    logic [WORD_W-1:0] conv;
    logic              c_inv, c_inx;
    logic              act;

    assign elem = bcast ? src_i[HALF_W-1:0] : src_i[j*HALF_W +: HALF_W];
    assign act  = (CNT_W'(j) < n_act);

    fp16_u32_lane u_cvt (
      .h_i   (elem),
      .rm_i  (rm),
      .val_o (conv),
      .inv_o (c_inv),
      .inx_o (c_inx)
    );

    cvt_lane_merge #(.W(WORD_W)) u_mrg (
      .active_i (act),
      .write_i  (~mask_en_i | mask_i[j]),
      .zero_i   (zero_i),
      .conv_i   (conv),
      .old_i    (dest_old_i[j*WORD_W +: WORD_W]),
      .inv_i    (c_inv),
      .inx_i    (c_inx),
      .word_o   (dest_d[j*WORD_W +: WORD_W]),
      .inv_o    (lane_inv[j]),
      .inx_o    (lane_inx[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      dest_o      <= '0;
      inval_o     <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        dest_o    <= dest_d;
        inval_o   <= |lane_inv;
        inexact_o <= |lane_inx;
      end
    end
  end
endmodule

// File: rtl/vcvt_lane_ctrl_chk.sv
module vcvt_lane_ctrl_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic [1:0]   vlen_i,
  input logic         src_mem_i,
  input logic         bcst_i,
  input logic [15:0]  mask_i,
  input logic         mask_en_i,
  input logic         zero_i,
  input logic [511:0] dest_old_i,
  input logic         out_valid_o,
  input logic [511:0] dest_o,
  input logic         inval_o,
  input logic         inexact_o
);
  assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  assert_idle_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  assert_upper_clear_128_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && vlen_i == 2'd0) |=> dest_o[511:128] == '0);

  assert_upper_clear_256_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && vlen_i == 2'd1) |=> dest_o[511:256] == '0);

  assert_all_zeroed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_en_i && zero_i && mask_i == '0) |=> dest_o == '0);

  assert_all_merged_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_en_i && !zero_i && mask_i == '0 && vlen_i[1])
      |=> dest_o == $past(dest_old_i));

  assert_masked_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_en_i && mask_i == '0) |=> (!inval_o && !inexact_o));
endmodule

bind vcvt_lane_ctrl vcvt_lane_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .vlen_i      (vlen_i),
  .src_mem_i   (src_mem_i),
  .bcst_i      (bcst_i),
  .mask_i      (mask_i),
  .mask_en_i   (mask_en_i),
  .zero_i      (zero_i),
  .dest_old_i  (dest_old_i),
  .out_valid_o (out_valid_o),
  .dest_o      (dest_o),
  .inval_o     (inval_o),
  .inexact_o   (inexact_o)
);

// File: tb/sim_vcvt_lane_ctrl.sv
`timescale 1ns/1ps
module sim_vcvt_lane_ctrl;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [1:0]   vlen_i = '0;
  logic [255:0] src_i = '0;
  logic         src_mem_i = 1'b0;
  logic         bcst_i = 1'b0;
  logic [1:0]   emb_rc_i = '0;
  logic [1:0]   glob_rc_i = '0;
  logic [15:0]  mask_i = '0;
  logic         mask_en_i = 1'b0;
  logic         zero_i = 1'b0;
  logic [511:0] dest_old_i = '0;
  logic         out_valid_o;
  logic [511:0] dest_o;
  logic         inval_o;
  logic         inexact_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [511:0] q_dest[$];
  logic [1:0]   q_flag[$];
  string        q_tag[$];

  always #4 clk_i = ~clk_i;

  vcvt_lane_ctrl u0 (.*);

  // reference: rounding 0 near-even, 1 down, 2 up, 3 toward zero
  function automatic logic [33:0] ref_cvt(input logic [15:0] h, input logic [1:0] rm);
    int  e;
    real x, fl, fr, r;
    int  ri;
    e = int'(h[14:10]);
    if (e == 31) return {2'b10, 32'hFFFF_FFFF};
    x = (e == 0) ? real'(h[9:0]) : real'(h[9:0]) + 1024.0;
    if (e == 0) e = 1;
    for (int k = 0; k < 25 - e; k++) x = x / 2.0;
    for (int k = 0; k < e - 25; k++) x = x * 2.0;
    if (h[15]) x = -x;
    fl = $floor(x);
    fr = x - fl;
    case (rm)
      2'd0: begin
        if (fr > 0.5) r = fl + 1.0;
        else if (fr < 0.5) r = fl;
        else r = (($rtoi(fl) & 1) != 0) ? fl + 1.0 : fl;
      end
      2'd1: r = fl;
      2'd2: r = (fr > 0.0) ? fl + 1.0 : fl;
      default: r = (x >= 0.0 || fr == 0.0) ? fl : fl + 1.0;
    endcase
    if (r < 0.0) return {2'b10, 32'hFFFF_FFFF};
    ri = $rtoi(r);
    return {1'b0, (fr != 0.0), 32'(ri)};
  endfunction

  task automatic issue(input logic [1:0] vl, input logic [255:0] src, input bit mem,
                       input bit bc, input logic [1:0] erc, input logic [1:0] grc,
                       input logic [15:0] m, input bit men, input bit z,
                       input logic [511:0] old, input string tag);
    logic [511:0] ed;
    logic [1:0]   ef;
    logic [1:0]   rm;
    logic [33:0]  lr;
    int           nl;
    @(negedge clk_i);
    in_valid_i = 1'b1; vlen_i = vl; src_i = src; src_mem_i = mem; bcst_i = bc;
    emb_rc_i = erc; glob_rc_i = grc; mask_i = m; mask_en_i = men; zero_i = z;
    dest_old_i = old;
    nl = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    rm = (!mem && vl[1] && bc) ? erc : grc;
    ed = '0; ef = '0;
    for (int j = 0; j < nl; j++) begin
      if (!men || m[j]) begin
        lr = ref_cvt(mem && bc ? src[15:0] : src[16*j +: 16], rm);
        ed[32*j +: 32] = lr[31:0];
        ef = ef | lr[33:32];
      end else if (!z) begin
        ed[32*j +: 32] = old[32*j +: 32];
      end
    end
    q_dest.push_back(ed);
    q_flag.push_back(ef);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rst_ni && out_valid_o) begin
        n_run++;
        if (q_dest.size() == 0) begin
          n_fail++;
          $display("FAIL R9 unexpected valid: got 1 exp 0");
        end else begin
          logic [511:0] ed;
          logic [1:0]   ef;
          string        tg;
          ed = q_dest.pop_front();
          ef = q_flag.pop_front();
          tg = q_tag.pop_front();
          if (dest_o !== ed) begin
            n_fail++;
            $display("FAIL %s dest got %h exp %h", tg, dest_o, ed);
          end
          n_run++;
          if ({inval_o, inexact_o} !== ef) begin
            n_fail++;
            $display("FAIL %s R8 flags got %b exp %b", tg, {inval_o, inexact_o}, ef);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  logic [15:0] pat[16] = '{16'h3C00, 16'h3E00, 16'h4100, 16'h3800, 16'hBC00, 16'hB400,
                          16'h7E00, 16'h7C00, 16'h7BFF, 16'h0001, 16'h4380, 16'h0000,
                          16'h8000, 16'h3A00, 16'h4D00, 16'hC000};

  function automatic logic [255:0] mk(input int rot);
    logic [255:0] s;
    for (int j = 0; j < 16; j++) s[16*j +: 16] = pat[(j + rot) % 16];
    return s;
  endfunction

  function automatic logic [255:0] fill(input logic [15:0] v);
    logic [255:0] s;
    for (int j = 0; j < 16; j++) s[16*j +: 16] = v;
    return s;
  endfunction

  function automatic logic [511:0] oldpat(input int k);
    logic [511:0] o;
    for (int j = 0; j < 16; j++) o[32*j +: 32] = 32'hA5A5_0000 + 32'(j * 17 + k);
    return o;
  endfunction

  initial begin
    logic [255:0] s_exact;
    repeat (3) @(posedge clk_i);
    #1;
    n_run++;
    if (out_valid_o !== 1'b0 || dest_o !== '0 || inval_o !== 1'b0 || inexact_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset state got %b/%h exp 0/0", out_valid_o, dest_o[31:0]);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R7: lengths, no mask
    issue(2'd0, mk(0), 0, 0, 2'd0, 2'd0, 16'h0000, 0, 0, oldpat(1), "R1 R7 len128");
    issue(2'd1, mk(0), 0, 0, 2'd0, 2'd0, 16'h0000, 0, 0, oldpat(2), "R1 R7 len256");
    issue(2'd2, mk(0), 0, 0, 2'd0, 2'd0, 16'h0000, 0, 0, oldpat(3), "R1 R2 len512");
    issue(2'd3, mk(3), 0, 0, 2'd0, 2'd0, 16'h0000, 0, 0, oldpat(4), "R1 code3");
    // R2: every rounding mode, several patterns
    for (int r = 0; r < 4; r++) begin
      issue(2'd2, mk(r * 5), 0, 0, 2'd0, 2'(r), 16'h0000, 0, 0, oldpat(r), "R2 modes");
    end
    // R3: embedded override only for 512 register with bit set
    issue(2'd2, fill(16'h4100), 0, 1, 2'd2, 2'd0, 16'h0000, 0, 0, oldpat(5), "R3 override");
    issue(2'd1, fill(16'h4100), 0, 1, 2'd2, 2'd0, 16'h0000, 0, 0, oldpat(5), "R3 len256 no override");
    issue(2'd2, fill(16'h4100), 0, 0, 2'd2, 2'd1, 16'h0000, 0, 0, oldpat(5), "R3 bit clear");
    // R4: broadcast from memory, global mode used
    issue(2'd2, mk(2), 1, 1, 2'd2, 2'd0, 16'h0000, 0, 0, oldpat(6), "R4 R3 bcast");
    issue(2'd0, mk(10), 1, 1, 2'd1, 2'd3, 16'h0000, 0, 0, oldpat(6), "R4 bcast128");
    issue(2'd2, mk(4), 1, 0, 2'd2, 2'd0, 16'h0000, 0, 0, oldpat(6), "R4 mem no bcast");
    // R5 R6: merge and zero masking
    issue(2'd2, mk(0), 0, 0, 2'd0, 2'd0, 16'hA5C3, 1, 0, oldpat(7), "R5 R6 merge");
    issue(2'd2, mk(0), 0, 0, 2'd0, 2'd0, 16'hA5C3, 1, 1, oldpat(7), "R5 R6 zero");
    issue(2'd1, mk(6), 0, 0, 2'd0, 2'd0, 16'h0000, 1, 0, oldpat(8), "R6 R7 merge all off");
    issue(2'd2, mk(1), 0, 0, 2'd0, 2'd0, 16'h0000, 1, 1, oldpat(8), "R6 zero all off");
    issue(2'd0, mk(0), 0, 0, 2'd0, 2'd0, 16'hFFF0, 1, 0, oldpat(9), "R7 mask beyond len");
    // R8: NaN only in masked or inactive lanes
    s_exact = fill(16'h3C00);
    s_exact[16*5 +: 16] = 16'h7E00;
    s_exact[16*9 +: 16] = 16'h3800;
    issue(2'd2, s_exact, 0, 0, 2'd0, 2'd0, 16'hFDDF, 1, 0, oldpat(10), "R8 masked flags");
    issue(2'd0, s_exact, 0, 0, 2'd0, 2'd0, 16'h0000, 0, 0, oldpat(10), "R8 inactive flags");
    issue(2'd2, s_exact, 0, 0, 2'd0, 2'd0, 16'h0020, 1, 1, oldpat(10), "R8 invalid lane");
    idle();
    // R9: output drops after idle edge
    @(negedge clk_i);
    #1;
    n_run++;
    if (out_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 idle valid got %b exp 0", out_valid_o);
    end
    // R9: back-to-back burst
    for (int k = 0; k < 8; k++) begin
      issue(2'(k % 3), mk(k), k[0], k[1], 2'(k), 2'(k + 1), 16'(k * 4661), k[2], k[0],
            oldpat(k + 20), "R9 burst");
    end
    idle();
    repeat (3) @(negedge clk_i);
    n_run++;
    if (q_dest.size() != 0) begin
      n_fail++;
      $display("FAIL R9 missing results got %0d pending exp 0", q_dest.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule